// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

An eight-input interrupt core. Each request line is captured into a request register. A per-line mode input makes the line either edge sensitive, where a rising transition latches a request, or level sensitive, where the latched bit tracks the pin. Latched requests that are not masked are ranked against a rotatable priority base. The winner is compared with the highest-ranked bit of the in-service register. A registered interrupt output, with the winning line number beside it, is raised only when the pending line strictly outranks all service in progress.

The surrounding logic answers the interrupt with a one-cycle acknowledge pulse. The acknowledge moves the current winner into service, or with automatic end-of-interrupt it only optionally rotates priority. A separate one-cycle pulse with a line number ends service of that specific line. A new mask value is loaded with a load strobe. The trigger modes, automatic end-of-interrupt, rotate-on-acknowledge and the nested mode that disregards the cascade line's service bit are all static inputs.

Top module: `irq_resolver`

## Requirements
- R1: A line in edge mode (level_mode bit 0) sets its req_latched bit one cycle after the clock edge that samples req_in going from 0 to 1. While the input stays high, the bit is not set again once an acknowledge has cleared it.
- R2: A line in level mode (level_mode bit 1) has its req_latched bit equal to the req_in value sampled on the previous clock edge.
- R3: A line whose mask bit is 1 never wins, but its req_latched bit is kept. The mask is loaded from mask_value on a cycle with mask_load high, and it resets to all zeros.
- R4: Ranks are assigned by visiting lines (base + k) mod 8 for k = 0..7. The first unmasked pending line visited wins. The base resets to 0.
- R5: irq_out and vec_out are registered and follow the state one cycle later. irq_out is 1 only when the winner's rank is strictly smaller than the rank of the highest in-service bit, with rank 8 meaning none. vec_out gives the winner's line number, or 7 when irq_out is 0.
- R6: An acknowledge while a winner exists sets that line's in_service bit when automatic end-of-interrupt is off. It clears the line's req_latched bit only in edge mode; a level-mode request stays set.
- R7: An acknowledge while there is no winner changes neither in_service nor req_latched.
- R8: With auto_eoi high, an acknowledge sets no in_service bit. If rotate_aeoi is also high, the base becomes (winner + 1) mod 8.
- R9: eoi_clr clears the in_service bit selected by eoi_sel. When an acknowledge sets that same bit in the same cycle, the bit ends up set.
- R10: With nested_special high, in_service bit 2 is left out of the in-service rank. A fresh request on line 2 can therefore raise irq_out while line 2 is still in service.
- R11: Reset clears req_latched, in_service, the mask, the base and the last-level history. After reset, irq_out is 0 and vec_out is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Interrupt request lines |
| level_mode | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_load | input | 1 | Load strobe for the mask register |
| mask_value | input | 8 | New mask, 1 blocks the line |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotate_aeoi | input | 1 | Rotate the priority base on an automatic end-of-interrupt |
| nested_special | input | 1 | Exclude the cascade line's service bit from the in-service rank |
| ack | input | 1 | Acknowledge pulse |
| eoi_clr | input | 1 | Specific end-of-service pulse |
| eoi_sel | input | 3 | Line whose service bit eoi_clr clears |
| irq_out | output | 1 | Registered interrupt request |
| vec_out | output | 3 | Registered winning line, 7 when idle |
| req_latched | output | 8 | Request register |
| in_service | output | 8 | In-service register |

## Verification
Directed patterns each isolate one behaviour:
- A single edge pulse that is held high shows one-shot capture.
- Two simultaneous lines and a later lower-priority arrival separate ranking from preemption against in-service bits.
- A level line that is acknowledged and then dropped shows the request tracking the pin.
- Masking a latched request shows that blocking is separate from latching.
- Rotating acknowledges with lines 0 and 2 pending show the base actually moving rank.
- A repeat request on line 2 under the nested mode tells that mode apart from the plain strict comparison.
A long pseudo-random stream then mixes trigger modes, masks, pulses and mode changes, and a behavioural model is compared against it on every cycle.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NIRQ     = 8,
  parameter int CASC_BIT = 2,
  localparam int IDW     = $clog2(NIRQ),
  localparam int RW      = IDW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] req_in,
  input  logic [NIRQ-1:0] level_mode,
  input  logic            mask_load,
  input  logic [NIRQ-1:0] mask_value,
  input  logic            auto_eoi,
  input  logic            rotate_aeoi,
  input  logic            nested_special,
  input  logic            ack,
  input  logic            eoi_clr,
  input  logic [IDW-1:0]  eoi_sel,
  output logic            irq_out,
  output logic [IDW-1:0]  vec_out,
  output logic [NIRQ-1:0] req_latched,
  output logic [NIRQ-1:0] in_service
);

  localparam logic [RW-1:0]   NONE  = RW'(NIRQ);
  localparam logic [IDW-1:0]  IDLE  = IDW'(NIRQ - 1);
  localparam logic [NIRQ-1:0] CASC1 = NIRQ'(1) << CASC_BIT;

  function automatic logic [NIRQ-1:0] rotr(input logic [NIRQ-1:0] v, input logic [IDW-1:0] s);
    logic [2*NIRQ-1:0] d;
    d = {v, v} >> s;
    return d[NIRQ-1:0];
  endfunction

  function automatic logic [RW-1:0] first_rank(input logic [NIRQ-1:0] v);
    logic [RW-1:0] r;
    r = NONE;
    for (int k = NIRQ - 1; k >= 0; k--)
      if (v[k]) r = RW'(k);
    return r;
  endfunction

  logic [NIRQ-1:0] irr_q, last_q, isr_q, mask_q;
  logic [IDW-1:0]  base_q, vec_q;
  logic            irq_q;

  logic [NIRQ-1:0] pend, isr_eff, take_bit, clr_bit, rise;
  logic [RW-1:0]   rank_p, rank_s;
  logic            win, take;
  logic [IDW-1:0]  win_id;

  assign pend     = irr_q & ~mask_q;
  assign isr_eff  = isr_q & ~(nested_special ? CASC1 : '0);
  assign rank_p   = first_rank(rotr(pend, base_q));
  assign rank_s   = first_rank(rotr(isr_eff, base_q));
  assign win      = rank_p < rank_s;
  assign win_id   = rank_p[IDW-1:0] + base_q;
  assign take     = ack & win;
  assign take_bit = take ? (NIRQ'(1) << win_id) : '0;
  assign clr_bit  = eoi_clr ? (NIRQ'(1) << eoi_sel) : '0;
  assign rise     = req_in & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      vec_q  <= IDLE;
    end else begin
      last_q <= req_in;
      irr_q  <= (level_mode & req_in) | (~level_mode & ((irr_q & ~take_bit) | rise));
      isr_q  <= (isr_q & ~clr_bit) | (auto_eoi ? '0 : take_bit);
      if (mask_load) mask_q <= mask_value;
      if (take && auto_eoi && rotate_aeoi) base_q <= win_id + 1'b1;
      irq_q  <= win;
      vec_q  <= win ? win_id : IDLE;
    end
  end

  assign irq_out     = irq_q;
  assign vec_out     = vec_q;
  assign req_latched = irr_q;
  assign in_service  = isr_q;

endmodule

module irq_resolver_chk #(
  parameter int NIRQ = 8,
  localparam int IDW = $clog2(NIRQ)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] req_in,
  input logic [NIRQ-1:0] level_mode,
  input logic            auto_eoi,
  input logic            rotate_aeoi,
  input logic            ack,
  input logic            eoi_clr,
  input logic [IDW-1:0]  eoi_sel,
  input logic            irq_out,
  input logic [IDW-1:0]  vec_out,
  input logic [NIRQ-1:0] req_latched,
  input logic [NIRQ-1:0] in_service,
  input logic [NIRQ-1:0] mask_q,
  input logic [IDW-1:0]  base_q,
  input logic            win,
  input logic [IDW-1:0]  win_id
);

  assert_ack_sets_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && win && !auto_eoi |=> in_service[$past(win_id)]);

  assert_rotate_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && win && auto_eoi && rotate_aeoi |=> base_q == IDW'($past(win_id) + 1'b1));

  assert_specific_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_clr && !(ack && win && !auto_eoi && win_id == eoi_sel) |=> !in_service[$past(eoi_sel)]);

  assert_idle_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !win && !eoi_clr |=> $stable(in_service));

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (req_latched & $past(level_mode)) == ($past(req_in) & $past(level_mode)));

  assert_unmasked_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((($past(req_latched) & ~$past(mask_q)) >> vec_out) & NIRQ'(1)) != '0);

endmodule

bind irq_resolver irq_resolver_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .level_mode(level_mode),
  .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .ack(ack), .eoi_clr(eoi_clr),
  .eoi_sel(eoi_sel), .irq_out(irq_out), .vec_out(vec_out), .req_latched(req_latched),
  .in_service(in_service), .mask_q(mask_q), .base_q(base_q), .win(win), .win_id(win_id)
);

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, level_mode = '0, mask_value = '0;
  logic       mask_load = 0, auto_eoi = 0, rotate_aeoi = 0, nested_special = 0;
  logic       ack = 0, eoi_clr = 0;
  logic [2:0] eoi_sel = '0;
  logic       irq_out;
  logic [2:0] vec_out;
  logic [7:0] req_latched, in_service;

  irq_resolver u0 (.*);

  always #10 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 0;

  bit [7:0] m_irr, m_last, m_isr, m_mask;
  int m_base, m_vec;
  bit m_irq;

  function automatic int rank_of(bit [7:0] v, int base);
    for (int k = 0; k < 8; k++) if (v[(k + base) % 8]) return k;
    return 8;
  endfunction

  task automatic model_step();
    int rp, rs, wid;
    bit w;
    bit [7:0] ie, nirr, nisr;
    if (!rst_n) begin
      m_irr = 0; m_last = 0; m_isr = 0; m_mask = 0; m_base = 0; m_irq = 0; m_vec = 7;
      return;
    end
    rp = rank_of(m_irr & ~m_mask, m_base);
    ie = m_isr;
    if (nested_special) ie[2] = 0;
    rs = rank_of(ie, m_base);
    w = rp < rs;
    wid = (rp + m_base) % 8;
    for (int i = 0; i < 8; i++) begin
      if (level_mode[i]) nirr[i] = req_in[i];
      else begin
        nirr[i] = m_irr[i];
        if (ack && w && wid == i) nirr[i] = 0;
        if (req_in[i] && !m_last[i]) nirr[i] = 1;
      end
    end
    nisr = m_isr;
    if (eoi_clr) nisr[eoi_sel] = 0;
    if (ack && w && !auto_eoi) nisr[wid] = 1;
    if (ack && w && auto_eoi && rotate_aeoi) m_base = (wid + 1) % 8;
    if (mask_load) m_mask = mask_value;
    m_last = req_in; m_irr = nirr; m_isr = nisr;
    m_irq = w; m_vec = w ? wid : 7;
  endtask

  task automatic check(string tag, string name, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, "irq_out", irq_out, m_irq);
    check(tag, "vec_out", vec_out, m_vec);
    check(tag, "req_latched", req_latched, m_irr);
    check(tag, "in_service", in_service, m_isr);
    ack = 0; eoi_clr = 0; mask_load = 0;
  endtask

  task automatic eoi(int n, string tag);
    eoi_clr = 1; eoi_sel = 3'(n); cyc(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R11"); cyc("R11");
    rst_n = 1; cyc("R11");
    check("R11", "vec_out after reset", vec_out, 7);

    // R1, R5: edge capture on line 3, held high
    req_in = 8'h08; cyc("R1"); cyc("R5");
    check("R5", "irq for line 3", {irq_out, vec_out}, {1'b1, 3'd3});
    ack = 1; cyc("R6"); cyc("R1"); cyc("R1");
    check("R1", "held edge not re-latched", req_latched[3], 0);
    // R4: line 1 preempts service of 3, line 5 does not
    req_in = 8'h2A; cyc("R4"); cyc("R4");
    check("R4", "line 1 preempts", vec_out, 1);
    ack = 1; cyc("R6"); cyc("R5");
    check("R5", "line 5 blocked by service", irq_out, 0);
    eoi(1, "R9"); eoi(3, "R9"); cyc("R5");
    check("R5", "line 5 after clears", vec_out, 5);
    ack = 1; cyc("R6"); eoi(5, "R9");
    req_in = 0; cyc("R1");

    // R2: level line 4
    level_mode = 8'h10; req_in = 8'h10; cyc("R2"); cyc("R2");
    ack = 1; cyc("R6");
    check("R6", "level request kept", req_latched[4], 1);
    req_in = 0; cyc("R2");
    check("R2", "level request drops", req_latched[4], 0);
    eoi(4, "R9"); level_mode = 0;

    // R3: mask keeps request latched
    mask_load = 1; mask_value = 8'h40; req_in = 8'h40; cyc("R3");
    req_in = 0; cyc("R3"); cyc("R3");
    check("R3", "masked no irq", {irq_out, req_latched[6]}, 2'b01);
    mask_load = 1; mask_value = 0; cyc("R3"); cyc("R3");
    check("R3", "unmasked irq", irq_out, 1);
    ack = 1; cyc("R6"); eoi(6, "R9");

    // R7: acknowledge with nothing pending
    ack = 1; cyc("R7");
    check("R7", "idle ack service", in_service, 0);

    // R8: auto EOI with rotation
    auto_eoi = 1; rotate_aeoi = 1;
    req_in = 8'h05; cyc("R8"); req_in = 0; cyc("R8");
    ack = 1; cyc("R8");
    check("R8", "no service bit", in_service, 0);
    cyc("R8");
    check("R8", "line 2 next", vec_out, 2);
    req_in = 8'h01; cyc("R8"); req_in = 0; cyc("R8");
    check("R8", "rotated base favours 2 over 0", vec_out, 2);
    ack = 1; cyc("R8"); cyc("R8");
    check("R8", "line 0 after rotation", vec_out, 0);
    ack = 1; cyc("R8"); cyc("R8");
    auto_eoi = 0; rotate_aeoi = 0;
    rst_n = 0; cyc("R11"); rst_n = 1; cyc("R11");

    // R10: special nested mode on line 2
    nested_special = 1;
    req_in = 8'h04; cyc("R10"); req_in = 0; cyc("R10");
    ack = 1; cyc("R10");
    req_in = 8'h04; cyc("R10"); req_in = 0; cyc("R10");
    check("R10", "nested repeat raises irq", irq_out, 1);
    nested_special = 0; cyc("R10"); cyc("R10");
    check("R10", "plain mode blocks repeat", irq_out, 0);
    eoi(2, "R9");

    // R9: ack and clear on the same line
    cyc("R9");
    ack = 1; eoi_clr = 1; eoi_sel = 2; cyc("R9");
    check("R9", "ack wins over clear", in_service[2], 1);
    eoi(2, "R9");

    // mixed pseudo-random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 512 == 0) begin
        level_mode = 8'($urandom); auto_eoi = 1'($urandom);
        rotate_aeoi = 1'($urandom); nested_special = 1'($urandom);
      end
      req_in = 8'($urandom) & 8'($urandom);
      ack = ($urandom % 4) == 0;
      eoi_clr = ($urandom % 3) == 0; eoi_sel = 3'($urandom);
      mask_load = ($urandom % 16) == 0; mask_value = 8'($urandom) & 8'($urandom);
      cyc("R4");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule